// File: doc/BRIEF.md
# Periodic Wake-Up Timer

This block is a free-running wake-up timer controlled through a single 8-bit control and status register. The register sits on a simple synchronous register port (select, write enable, write data, read data). Once enabled, the timer counts ticks of one of two sources: a slow autonomous tick that arrives as a one-cycle clock-enable strobe, or every cycle of the bus clock. No clock is switched. When the programmed interval has passed, the timer sets a sticky timeout flag and reloads itself. The flag can raise an interrupt request.

The interval comes from a 16-bit period input held outside the block. The timeout interval is (period + 1) × 2 ticks. An optional external waveform output shows each timeout to the rest of the chip. It can be a short high pulse one tick wide, or a square wave that changes level at every timeout. The clock-source choice is locked while the timer runs, so the time base cannot change under a running count.

Top module: `pit_wakeup_timer`

## Requirements
- R1: After reset the register reads 0x00, and `irq` and `ext_wave` are low.
- R2: Register bits: 7 = source select (0 autonomous tick, 1 bus clock), 4 = waveform select, 3 = external output enable, 2 = timer enable, 1 = interrupt enable, 0 = timeout flag. Bits 6 and 5 always read 0. `reg_rdata` shows the register while `reg_sel` is high and is 0 otherwise.
- R3: The source-select bit is updated by a write only if the timer enable is 0 before the write and the written enable bit is 0. Otherwise it keeps its value.
- R4: With the timer enabled, the flag is set after (period + 1) × 2 counted ticks. Ticks are counted from the cycle after the enabling write. In bus-clock mode every cycle is a tick. In autonomous mode only cycles with `auto_tick` high count. The count reloads at each timeout.
- R5: Writing 1 to bit 0 clears the flag, and writing 0 leaves it unchanged. If a timeout and a clearing write fall in the same cycle, the flag stays set.
- R6: `irq` is high exactly when the flag and the interrupt enable are both 1.
- R7: Clearing the timer enable resets the count. A later enable starts a full new interval.
- R8: `ext_wave` is low unless the external output enable and the timer enable are both 1.
- R9: In pulse mode (waveform select 0), `ext_wave` goes high in the cycle after a timeout and stays high until the next counted tick, which is one tick wide.
- R10: In square-wave mode (waveform select 1), `ext_wave` changes level at each timeout. Its period is therefore twice the timeout interval. Its level returns to 0 whenever the timer is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| auto_tick | input | 1 | One-cycle strobe from the slow autonomous time base |
| reg_sel | input | 1 | Register select |
| reg_we | input | 1 | Write enable, qualified by `reg_sel` |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, 0 when not selected |
| period_val | input | 16 | Period setting |
| irq | output | 1 | Interrupt request |
| ext_wave | output | 1 | External timeout waveform |

## Verification
Timeout timing is first tried in bus-clock mode with a period of 2, where the flag must appear exactly six cycles after enabling. This exposes off-by-one errors in the reload compare and in the enable edge. The same function is then driven in autonomous mode with a sparse strobe, every third cycle. That separates a design that counts ticks from one that counts cycles, and shows that the pulse lasts until the next tick rather than for one cycle. Clearing writes are placed on the exact timeout cycle and on ordinary cycles, which tells set priority apart from clear priority. Writes to the source-select bit are made while running, while enabling, and while idle, to show where the lock applies.

// File: rtl/pit_pkg.sv
package pit_pkg;

  localparam int unsigned REG_W   = 8;
  localparam int unsigned B_SRC   = 7;
  localparam int unsigned B_WAVE  = 4;
  localparam int unsigned B_EXT   = 3;
  localparam int unsigned B_EN    = 2;
  localparam int unsigned B_IE    = 1;
  localparam int unsigned B_FLAG  = 0;

  typedef struct packed {
    logic src_bus;
    logic wave_sq;
    logic ext_on;
    logic run;
    logic irq_on;
    logic flag;
  } pit_ctrl_t;

endpackage

// File: rtl/pit_ctrl_reg.sv
module pit_ctrl_reg
  import pit_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_stb,
  input  logic [REG_W-1:0] wdata,
  input  logic             timeout,
  output pit_ctrl_t        ctrl_q,
  output logic [REG_W-1:0] rd_word
);

  pit_ctrl_t ctrl_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_stb) begin
      ctrl_d.wave_sq = wdata[B_WAVE];
      ctrl_d.ext_on  = wdata[B_EXT];
      ctrl_d.run     = wdata[B_EN];
      ctrl_d.irq_on  = wdata[B_IE];
      // source select only while idle and not being enabled now
      if (!ctrl_q.run && !wdata[B_EN]) begin
        ctrl_d.src_bus = wdata[B_SRC];
      end
      if (wdata[B_FLAG]) begin
        ctrl_d.flag = 1'b0;
      end
    end
    // hardware set wins over software clear
    if (timeout) begin
      ctrl_d.flag = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else begin
      ctrl_q <= ctrl_d;
    end
  end

  always_comb begin
    rd_word         = '0;
    rd_word[B_SRC]  = ctrl_q.src_bus;
    rd_word[B_WAVE] = ctrl_q.wave_sq;
    rd_word[B_EXT]  = ctrl_q.ext_on;
    rd_word[B_EN]   = ctrl_q.run;
    rd_word[B_IE]   = ctrl_q.irq_on;
    rd_word[B_FLAG] = ctrl_q.flag;
  end

endmodule

// File: rtl/pit_tick_counter.sv
module pit_tick_counter #(
  parameter int unsigned PERIOD_W = 16,
  localparam int unsigned CNT_W   = PERIOD_W + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run,
  input  logic                tick,
  input  logic [PERIOD_W-1:0] period,
  output logic                timeout,
  output logic [CNT_W-1:0]    cnt_q
);

  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] last_val;

  // interval of (period+1)*2 ticks: count 0 .. 2*period+1
  assign last_val = {period, 1'b1};
  assign timeout  = run && tick && (cnt_q == last_val);

  always_comb begin
    cnt_d = cnt_q;
    if (!run) begin
      cnt_d = '0;
    end else if (tick) begin
      if (cnt_q == last_val) begin
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/pit_wave_gen.sv
module pit_wave_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  input  logic timeout,
  input  logic ext_on,
  input  logic wave_sq,
  output logic wave,
  output logic pulse_q,
  output logic toggle_q
);

  logic pulse_d;
  logic toggle_d;

  always_comb begin
    pulse_d  = pulse_q;
    toggle_d = toggle_q;
    if (!run) begin
      pulse_d  = 1'b0;
      toggle_d = 1'b0;
    end else begin
      if (tick) begin
        pulse_d = timeout;
      end
      if (timeout) begin
        toggle_d = ~toggle_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_q  <= 1'b0;
      toggle_q <= 1'b0;
    end else begin
      pulse_q  <= pulse_d;
      toggle_q <= toggle_d;
    end
  end

  assign wave = run && ext_on && (wave_sq ? toggle_q : pulse_q);

endmodule

// File: rtl/pit_wakeup_timer.sv
module pit_wakeup_timer
  import pit_pkg::*;
#(
  parameter int unsigned PERIOD_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                auto_tick,
  input  logic                reg_sel,
  input  logic                reg_we,
  input  logic [REG_W-1:0]    reg_wdata,
  output logic [REG_W-1:0]    reg_rdata,
  input  logic [PERIOD_W-1:0] period_val,
  output logic                irq,
  output logic                ext_wave
);

  localparam int unsigned CNT_W = PERIOD_W + 1;

  logic             rst_meta_n;
  logic             rst_sync_n;
  pit_ctrl_t        ctrl;
  logic [REG_W-1:0] rd_word;
  logic             wr_stb;
  logic             tick;
  logic             timeout;
  logic [CNT_W-1:0] cnt;
  logic             pulse;
  logic             toggle;
  logic             feat_en;
  logic             src_bus;
  logic             flag;
  logic             ext_on;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  assign wr_stb  = reg_sel && reg_we;
  assign feat_en = ctrl.run;
  assign src_bus = ctrl.src_bus;
  assign flag    = ctrl.flag;
  assign ext_on  = ctrl.ext_on;
  assign tick    = src_bus || auto_tick;

  pit_ctrl_reg u_ctrl (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_stb  (wr_stb),
    .wdata   (reg_wdata),
    .timeout (timeout),
    .ctrl_q  (ctrl),
    .rd_word (rd_word)
  );

  pit_tick_counter #(.PERIOD_W(PERIOD_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .run     (feat_en),
    .tick    (tick),
    .period  (period_val),
    .timeout (timeout),
    .cnt_q   (cnt)
  );

  pit_wave_gen u_wave (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .run      (feat_en),
    .tick     (tick),
    .timeout  (timeout),
    .ext_on   (ext_on),
    .wave_sq  (ctrl.wave_sq),
    .wave     (ext_wave),
    .pulse_q  (pulse),
    .toggle_q (toggle)
  );

  assign reg_rdata = reg_sel ? rd_word : '0;
  assign irq       = flag && ctrl.irq_on;

endmodule

// File: rtl/pit_wakeup_timer_chk.sv
module pit_wakeup_timer_chk #(
  parameter int unsigned CNT_W = 17
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_clr,
  input logic             feat_en,
  input logic             src_bus,
  input logic             flag,
  input logic             timeout,
  input logic [CNT_W-1:0] cnt,
  input logic             pulse,
  input logic             toggle,
  input logic             ext_on,
  input logic             ext_wave
);

  assert_src_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(feat_en) |-> $stable(src_bus));

  assert_flag_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |=> flag);

  assert_flag_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag) |-> $past(wr_clr));

  assert_idle_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !feat_en |=> (cnt == '0));

  assert_ext_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ext_wave |-> (feat_en && ext_on));

  assert_pulse_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse) |-> $past(timeout));

  assert_toggle_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(toggle) |-> ($past(timeout) || !$past(feat_en)));

endmodule

bind pit_wakeup_timer pit_wakeup_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .wr_clr   (reg_sel && reg_we && reg_wdata[0]),
  .feat_en  (feat_en),
  .src_bus  (src_bus),
  .flag     (flag),
  .timeout  (timeout),
  .cnt      (cnt),
  .pulse    (pulse),
  .toggle   (toggle),
  .ext_on   (ext_on),
  .ext_wave (ext_wave)
);

// File: tb/pit_wakeup_timer_tb.sv
module pit_wakeup_timer_tb;

  localparam int K_RD  = 0;
  localparam int K_IRQ = 1;
  localparam int K_EXT = 2;

  typedef struct {
    int         cyc;
    int         kind;
    logic [7:0] val;
    string      req;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        auto_tick;
  logic        reg_sel;
  logic        reg_we;
  logic [7:0]  reg_wdata;
  logic [7:0]  reg_rdata;
  logic [15:0] period_val;
  logic        irq;
  logic        ext_wave;

  int   cyc = 0;
  int   n_checks = 0;
  int   n_errors = 0;
  bit   done = 1'b0;
  exp_t sb[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pit_wakeup_timer u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .auto_tick  (auto_tick),
    .reg_sel    (reg_sel),
    .reg_we     (reg_we),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .period_val (period_val),
    .irq        (irq),
    .ext_wave   (ext_wave)
  );

  // monitor: compare expectations of the current cycle away from the edge
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].cyc <= cyc) begin
      exp_t it;
      logic [7:0] got;
      it = sb.pop_front();
      case (it.kind)
        K_RD:    got = reg_rdata;
        K_IRQ:   got = {7'd0, irq};
        default: got = {7'd0, ext_wave};
      endcase
      n_checks++;
      if (got !== it.val) begin
        n_errors++;
        $display("FAIL %s kind=%0d cyc=%0d actual=0x%02h expected=0x%02h",
                 it.req, it.kind, cyc, got, it.val);
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) tick();
  endtask

  task automatic push(input int kind, input logic [7:0] v, input string req);
    sb.push_back('{cyc, kind, v, req});
  endtask

  task automatic wr(input logic [7:0] d);
    reg_sel = 1'b1; reg_we = 1'b1; reg_wdata = d;
    tick();
    reg_sel = 1'b0; reg_we = 1'b0; reg_wdata = 8'h00;
  endtask

  task automatic rd(input logic [7:0] v, input string req);
    reg_sel = 1'b1; reg_we = 1'b0;
    push(K_RD, v, req);
    tick();
    reg_sel = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    int t0;
    int t1;
    int n;
    bit pl;
    rst_n = 1'b0; auto_tick = 1'b0; reg_sel = 1'b0; reg_we = 1'b0;
    reg_wdata = 8'h00; period_val = 16'd2;
    repeat (4) tick();
    rst_n = 1'b1;
    repeat (4) tick();

    // R1 reset state
    rd(8'h00, "R1");
    push(K_IRQ, 0, "R1");
    push(K_EXT, 0, "R1");
    tick();

    // R2 field positions, reserved bits read 0
    wr(8'hFA);
    rd(8'h9A, "R2");
    push(K_RD, 8'h00, "R2 unselected");
    tick();
    wr(8'h00);
    rd(8'h00, "R2");

    // R3 source-select lock
    wr(8'h04);
    wr(8'h84);
    rd(8'h04, "R3 running");
    wr(8'h00);
    wr(8'h84);
    rd(8'h04, "R3 same write");
    wr(8'h00);
    wr(8'h80);
    rd(8'h80, "R3 idle");

    // R4 bus clock, period 2 -> 6 cycles
    wr(8'h86);
    t0 = cyc;
    wait_until(t0 + 5);
    push(K_IRQ, 0, "R4 early");
    tick();
    push(K_IRQ, 1, "R4 timeout");
    rd(8'h87, "R4 flag");
    // R5 set beats clear on the timeout cycle (t0+12)
    wait_until(t0 + 11);
    wr(8'h87);
    push(K_IRQ, 1, "R5 set wins");
    wr(8'h87);
    push(K_IRQ, 0, "R5 clear");
    wait_until(t0 + 18);
    push(K_IRQ, 1, "R4 reload");
    // R6 irq enable off, flag kept by writing 0
    wr(8'h84);
    push(K_IRQ, 0, "R6");
    rd(8'h85, "R5 write0");
    wr(8'h81);
    rd(8'h80, "R5 cleared");

    // R7 disable mid-interval restarts
    wr(8'h86);
    t1 = cyc;
    wait_until(t1 + 3);
    wr(8'h82);
    wr(8'h86);
    t0 = cyc;
    for (int k = 1; k <= 5; k++) begin
      wait_until(t0 + k);
      push(K_IRQ, 0, "R7 restart");
    end
    tick();
    push(K_IRQ, 1, "R7 full interval");
    wr(8'h81);

    // R9 pulse mode
    wr(8'h8E);
    t0 = cyc;
    for (int k = 1; k <= 13; k++) begin
      wait_until(t0 + k);
      push(K_EXT, (k == 6 || k == 12) ? 8'd1 : 8'd0, "R9 pulse");
    end
    // R8 gate by external enable
    wr(8'h86);
    wait_until(t0 + 18);
    push(K_EXT, 0, "R8 ext off");
    push(K_IRQ, 1, "R6 on");
    wr(8'h88);
    push(K_EXT, 0, "R8 timer off");
    tick();
    push(K_EXT, 0, "R8 timer off");
    wr(8'h89);

    // R10 square wave
    wr(8'h9C);
    t0 = cyc;
    for (int k = 1; k <= 19; k++) begin
      wait_until(t0 + k);
      push(K_EXT, ((k / 6) % 2 == 1) ? 8'd1 : 8'd0, "R10 toggle");
    end
    wr(8'h98);
    push(K_EXT, 0, "R10 disabled");
    wr(8'h9C);
    t0 = cyc;
    for (int k = 1; k <= 6; k++) begin
      wait_until(t0 + k);
      push(K_EXT, (k == 6) ? 8'd1 : 8'd0, "R10 level reset");
    end
    wr(8'h99);

    // R4/R9 autonomous tick mode, period 1 -> 4 ticks
    wr(8'h08);
    rd(8'h08, "R3 select auto");
    period_val = 16'd1;
    wr(8'h0E);
    n = 0;
    pl = 1'b0;
    for (int i = 0; i < 30; i++) begin
      auto_tick = (i % 3 == 2);
      tick();
      if (auto_tick) begin
        n++;
        pl = (n % 4 == 0);
      end
      push(K_IRQ, (n >= 4) ? 8'd1 : 8'd0, "R4 auto ticks");
      push(K_EXT, pl ? 8'd1 : 8'd0, "R9 auto pulse");
    end
    auto_tick = 1'b0;

    repeat (3) tick();
    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule